// File: doc/BRIEF.md
# Dual Channel Interval Timer

This peripheral holds a parameterised number of identical up-counting interval timers. The default is two channels with 32-bit counters. A simple word-addressed register port drives it: an address, a write strobe, write data, and read data that follows the address combinationally. Software does not edit a control word. It writes one-shot command words to start a channel, stop it or clear its count, and it writes an acknowledge word to drop a pending event. A per-channel mode word chooses between repeating operation and single-event operation.

Each channel compares its running count against an active limit. On a match the channel raises a pending flag. In repeating mode the count then starts again from zero. In single-event mode the channel halts with the count at the limit. The interrupt line of a channel is its pending flag gated by its own interrupt enable. A new limit or mode that software writes is held in a staging register. It becomes active only when software next starts or clears the channel, so a running period is never cut short by a write. A global clock-request bit has to be set before any channel advances.

Top module: `gpt_dual`

## Requirements
- R1: After reset every channel reads as follows: count 0, stopped, limit all ones, repeating mode, interrupt enable 0, nothing pending. The clock-request bit reads 0 and every interrupt line is low.
- R2: Word 0x00, bit 0, is the clock-request bit, which software can read back. While it is 0 no channel count advances, even on a running channel.
- R3: A running channel adds one to its count on each clock. Writing bit 0 = 1 to the start word (offset 0) runs the channel from its held count. A cycle that carries a start, stop or clear write does not advance that channel.
- R4: In repeating mode (mode bit 0 = 0) the channel sets pending and the count returns to 0 on the clock where the count equals the limit, which gives a period of limit + 1 clocks. With a limit of all ones the count runs freely and wraps.
- R5: In single-event mode (mode word, offset 3, bit 0 = 1) a match sets pending and stops the channel. The count stays at the limit.
- R6: A channel's interrupt is high exactly when its pending flag and its interrupt enable (offset 5, bit 0) are both set.
- R7: Writing bit 0 = 1 to the acknowledge word (offset 6) clears pending.
- R8: A match in the same cycle as an acknowledge leaves pending set.
- R9: A stop write (offset 1) freezes the count without clearing it. A clear write (offset 2) sets the count to 0 and leaves the run state unchanged.
- R10: A limit (offset 4) or mode written while the channel runs reads back at once. It governs matching only from the next start or clear.
- R11: The count reads at offset 7. The command words (offsets 0, 1, 2, 6) and every unmapped address read 0.
- R12: A start, stop, clear or acknowledge write with bit 0 = 0 has no effect.
- R13: Channel c occupies word addresses 16·(c+1) to 16·(c+1)+15. Channels operate independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every counter tick is one clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
A write takes effect at the clock edge that samples it, so a read issued on the next cycle already shows the new staging value or count. A started channel whose count was 0 matches on the edge limit + 1 clocks after the start edge, and its interrupt rises just after that same edge. The bench keeps a per-cycle reference state that it updates at the same edge the design uses. It drives inputs at the falling edge and compares read data and interrupt lines just after that falling edge, before the next rising edge. Each comparison therefore sees the state produced by all earlier writes and none of the pending one.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   // channel window geometry (word addresses)
   localparam int OFF_W   = 4;
   localparam int CH_BLK0 = 1;   // channel c lives in block CH_BLK0 + c

   localparam logic [OFF_W-1:0] OFF_START  = 4'd0;
   localparam logic [OFF_W-1:0] OFF_STOP   = 4'd1;
   localparam logic [OFF_W-1:0] OFF_CLEAR  = 4'd2;
   localparam logic [OFF_W-1:0] OFF_MODE   = 4'd3;
   localparam logic [OFF_W-1:0] OFF_LIMIT  = 4'd4;
   localparam logic [OFF_W-1:0] OFF_IRQEN  = 4'd5;
   localparam logic [OFF_W-1:0] OFF_IRQACK = 4'd6;
   localparam logic [OFF_W-1:0] OFF_COUNT  = 4'd7;

   // decoded per-channel write actions for one cycle
   typedef struct packed {
      logic start;
      logic stop;
      logic clear;
      logic ack;
      logic wr_mode;
      logic wr_limit;
      logic wr_irqen;
   } ch_cmd_t;

endpackage

// File: rtl/gpt_regdec.sv
module gpt_regdec #(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 8
) (
   input  logic                               we,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic                               wbit,
   output logic                               wr_clkreq,
   output gpt_pkg::ch_cmd_t [NUM_CH-1:0]      cmd
);
   import gpt_pkg::*;

   localparam int BLK_W = ADDR_W - OFF_W;

   logic [OFF_W-1:0] off;
   logic [BLK_W-1:0] blk;

   assign off       = addr[OFF_W-1:0];
   assign blk       = addr[ADDR_W-1:OFF_W];
   assign wr_clkreq = we && (addr == '0);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(CH_BLK0 + c);
      logic sel;
      assign sel = we && (blk == MY_BLK);

      always_comb begin
         cmd[c]          = '0;
         cmd[c].start    = sel && (off == OFF_START)  && wbit;
         cmd[c].stop     = sel && (off == OFF_STOP)   && wbit;
         cmd[c].clear    = sel && (off == OFF_CLEAR)  && wbit;
         cmd[c].ack      = sel && (off == OFF_IRQACK) && wbit;
         cmd[c].wr_mode  = sel && (off == OFF_MODE);
         cmd[c].wr_limit = sel && (off == OFF_LIMIT);
         cmd[c].wr_irqen = sel && (off == OFF_IRQEN);
      end
   end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_ok,
   input  gpt_pkg::ch_cmd_t cmd,
   input  logic [CNT_W-1:0] wval,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] limit_stage,
   output logic             mode_stage,
   output logic             irq_en,
   output logic             pend,
   output logic             running,
   output logic             oneshot_act,
   output logic             match,
   output logic             irq
);

   logic [CNT_W-1:0] limit_act;
   logic             advance;
   logic             any_ctl;

   assign any_ctl = cmd.start | cmd.stop | cmd.clear;
   assign advance = running && tick_ok && !any_ctl;
   assign match   = advance && (count == limit_act);
   assign irq     = pend && irq_en;

   // staging registers: software-visible, no effect on the live period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_stage <= '1;
         mode_stage  <= 1'b0;
         irq_en      <= 1'b0;
      end else begin
         if (cmd.wr_limit) limit_stage <= wval;
         if (cmd.wr_mode)  mode_stage  <= wval[0];
         if (cmd.wr_irqen) irq_en      <= wval[0];
      end
   end

   // event flag: a match outranks an acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= 1'b0;
      else if (match)     pend <= 1'b1;
      else if (cmd.ack)   pend <= 1'b0;
   end

   // counter, run state and active configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count       <= '0;
         running     <= 1'b0;
         limit_act   <= '1;
         oneshot_act <= 1'b0;
      end else if (cmd.clear) begin
         count       <= '0;
         limit_act   <= limit_stage;
         oneshot_act <= mode_stage;
      end else if (cmd.start) begin
         running     <= 1'b1;
         limit_act   <= limit_stage;
         oneshot_act <= mode_stage;
      end else if (cmd.stop) begin
         running     <= 1'b0;
      end else if (advance) begin
         if (match) begin
            if (oneshot_act) running <= 1'b0;
            else             count   <= '0;
         end else begin
            count <= count + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/gpt_rdmux.sv
module gpt_rdmux #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          clk_req,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  count,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  limit_stage,
   input  logic [NUM_CH-1:0]             mode_stage,
   input  logic [NUM_CH-1:0]             irq_en,
   output logic [DATA_W-1:0]             rdata
);
   import gpt_pkg::*;

   localparam int BLK_W = ADDR_W - OFF_W;

   logic [OFF_W-1:0] off;
   logic [BLK_W-1:0] blk;
   assign off = addr[OFF_W-1:0];
   assign blk = addr[ADDR_W-1:OFF_W];

   always_comb begin
      rdata = '0;
      if (addr == '0) rdata[0] = clk_req;
      for (int c = 0; c < NUM_CH; c++) begin
         if (blk == BLK_W'(CH_BLK0 + c)) begin
            case (off)
               OFF_MODE:  rdata[0]       = mode_stage[c];
               OFF_LIMIT: rdata[CNT_W-1:0] = limit_stage[c];
               OFF_IRQEN: rdata[0]       = irq_en[c];
               OFF_COUNT: rdata[CNT_W-1:0] = count[c];
               default:   rdata          = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/gpt_dual.sv
module gpt_dual #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   import gpt_pkg::*;

   // elaboration checks
   if (NUM_CH < 1) begin : g_bad_nch
      $error("gpt_dual: NUM_CH must be at least 1");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("gpt_dual: CNT_W must be in 2..DATA_W");
   end
   if ((NUM_CH + CH_BLK0) > (1 << (ADDR_W - OFF_W))) begin : g_bad_addr
      $error("gpt_dual: ADDR_W too small for NUM_CH windows");
   end

   ch_cmd_t [NUM_CH-1:0]            cmd;
   logic                            wr_clkreq;
   logic                            clk_req;
   logic [NUM_CH-1:0][CNT_W-1:0]    ch_count;
   logic [NUM_CH-1:0][CNT_W-1:0]    ch_limit;
   logic [NUM_CH-1:0]               ch_mode;
   logic [NUM_CH-1:0]               ch_ie;
   logic [NUM_CH-1:0]               ch_pend;
   logic [NUM_CH-1:0]               ch_run;
   logic [NUM_CH-1:0]               ch_oneshot;
   logic [NUM_CH-1:0]               ch_hit;

   gpt_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .we        (bus_we),
      .addr      (bus_addr),
      .wbit      (bus_wdata[0]),
      .wr_clkreq (wr_clkreq),
      .cmd       (cmd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         clk_req <= 1'b0;
      else if (wr_clkreq) clk_req <= bus_wdata[0];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      gpt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .tick_ok     (clk_req),
         .cmd         (cmd[c]),
         .wval        (bus_wdata[CNT_W-1:0]),
         .count       (ch_count[c]),
         .limit_stage (ch_limit[c]),
         .mode_stage  (ch_mode[c]),
         .irq_en      (ch_ie[c]),
         .pend        (ch_pend[c]),
         .running     (ch_run[c]),
         .oneshot_act (ch_oneshot[c]),
         .match       (ch_hit[c]),
         .irq         (irq[c])
      );
   end

   gpt_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .addr        (bus_addr),
      .clk_req     (clk_req),
      .count       (ch_count),
      .limit_stage (ch_limit),
      .mode_stage  (ch_mode),
      .irq_en      (ch_ie),
      .rdata       (bus_rdata)
   );

endmodule

// File: rtl/gpt_dual_chk.sv
module gpt_dual_chk #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          clk_req,
   input gpt_pkg::ch_cmd_t [NUM_CH-1:0] cmd,
   input logic [NUM_CH-1:0][CNT_W-1:0]  ch_count,
   input logic [NUM_CH-1:0]             ch_run,
   input logic [NUM_CH-1:0]             ch_pend,
   input logic [NUM_CH-1:0]             ch_hit,
   input logic [NUM_CH-1:0]             ch_oneshot
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_a
      // R9 and R2: no run or no clock request, no clear -> count holds
      assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ((!ch_run[c] || !clk_req) && !cmd[c].clear) |=> $stable(ch_count[c]));

      assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_run[c] && clk_req && !cmd[c].start && !cmd[c].stop && !cmd[c].clear && !ch_hit[c])
         |=> (ch_count[c] == $past(ch_count[c]) + CNT_W'(1)));

      assert_repeat_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_hit[c] && !ch_oneshot[c]) |=> (ch_count[c] == '0));

      assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_hit[c] && ch_oneshot[c]) |=> (!ch_run[c] && $stable(ch_count[c])));

      assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd[c].ack && !ch_hit[c]) |=> !ch_pend[c]);

      assert_match_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ch_hit[c] |=> ch_pend[c]);
   end

endmodule

bind gpt_dual gpt_dual_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_req    (clk_req),
   .cmd        (cmd),
   .ch_count   (ch_count),
   .ch_run     (ch_run),
   .ch_pend    (ch_pend),
   .ch_hit     (ch_hit),
   .ch_oneshot (ch_oneshot)
);

// File: tb/gpt_dual_tb.sv
`timescale 1ns/1ps
module gpt_dual_tb;
   localparam int NCH = 2;
   localparam int AW  = 8;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   wire  [DW-1:0] rdata;
   wire  [NCH-1:0] irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;
   logic [31:0] last_rd;

   // reference state, built from the requirements
   logic [31:0] m_cnt [NCH];
   logic [31:0] m_lsh [NCH];
   logic [31:0] m_lact[NCH];
   bit          m_run [NCH];
   bit          m_msh [NCH];
   bit          m_mact[NCH];
   bit          m_ie  [NCH];
   bit          m_pend[NCH];
   bit          m_creq;

   always #5 clk = ~clk;

   gpt_dual #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

   function automatic logic [AW-1:0] ca(int c, int off);
      return AW'(16 + 16*c + off);
   endfunction

   function automatic logic [31:0] exp_read(logic [AW-1:0] a);
      if (a == 0) return {31'd0, m_creq};
      for (int c = 0; c < NCH; c++) begin
         if (int'(a) >= 16 + 16*c && int'(a) < 32 + 16*c) begin
            case (int'(a) - 16 - 16*c)
               3: return {31'd0, m_msh[c]};
               4: return m_lsh[c];
               5: return {31'd0, m_ie[c]};
               7: return m_cnt[c];
               default: return 32'd0;
            endcase
         end
      end
      return 32'd0;
   endfunction

   function automatic logic [31:0] exp_irq();
      logic [31:0] v = '0;
      for (int c = 0; c < NCH; c++) v[c] = m_pend[c] & m_ie[c];
      return v;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         m_cnt[c] = 0; m_lsh[c] = '1; m_lact[c] = '1;
         m_run[c] = 0; m_msh[c] = 0; m_mact[c] = 0; m_ie[c] = 0; m_pend[c] = 0;
      end
      m_creq = 0;
   endtask

   task automatic model_clock(bit w, logic [AW-1:0] a, logic [31:0] d);
      bit old_creq = m_creq;
      for (int c = 0; c < NCH; c++) begin
         int  off  = int'(a) - 16 - 16*c;
         bit  win  = w && off >= 0 && off < 16;
         bit  go   = win && off == 0 && d[0];
         bit  halt = win && off == 1 && d[0];
         bit  clr  = win && off == 2 && d[0];
         bit  ak   = win && off == 6 && d[0];
         bit  adv, hit;
         if (win && off == 3) m_msh[c] = d[0];
         if (win && off == 4) m_lsh[c] = d;
         if (win && off == 5) m_ie[c]  = d[0];
         adv = m_run[c] && old_creq && !(go || halt || clr);
         hit = adv && (m_cnt[c] == m_lact[c]);
         if (hit) m_pend[c] = 1; else if (ak) m_pend[c] = 0;
         if (clr) begin
            m_cnt[c] = 0; m_lact[c] = m_lsh[c]; m_mact[c] = m_msh[c];
         end else if (go) begin
            m_run[c] = 1; m_lact[c] = m_lsh[c]; m_mact[c] = m_msh[c];
         end else if (halt) begin
            m_run[c] = 0;
         end else if (adv) begin
            if (!hit)          m_cnt[c] = m_cnt[c] + 1;
            else if (m_mact[c]) m_run[c] = 0;
            else                m_cnt[c] = 0;
         end
      end
      if (w && a == 0) m_creq = d[0];
   endtask

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   task automatic bus(bit w, logic [AW-1:0] a, logic [31:0] d, string tag);
      @(negedge clk);
      we = w; addr = a; wdata = d;
      #1;
      if (!w) begin
         chk(tag, rdata, exp_read(a));
         last_rd = rdata;
      end
      chk({tag, " irq"}, {{(32-NCH){1'b0}}, irq}, exp_irq());
      @(posedge clk);
      model_clock(w, a, d);
   endtask

   task automatic rd(logic [AW-1:0] a, string tag);
      bus(0, a, 32'd0, tag);
   endtask
   task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
      bus(1, a, d, tag);
   endtask
   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) bus(0, AW'(1), 32'd0, tag);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset contents
      rd(AW'(0), "R1");
      for (int c = 0; c < NCH; c++) begin
         rd(ca(c,3), "R1"); rd(ca(c,4), "R1"); rd(ca(c,5), "R1"); rd(ca(c,7), "R1");
      end
      chk("R1 limit", exp_read(ca(0,4)), 32'hFFFF_FFFF);

      // R2: running channel without clock request stays at 0
      wr(ca(0,4), 32'd100, "R2");
      wr(ca(0,0), 32'd1,   "R2");
      idle(4, "R2");
      rd(ca(0,7), "R2");
      chk("R2 count", last_rd, 32'd0);

      // R3: counting once the clock request is set
      wr(AW'(0), 32'd1, "R3");
      idle(5, "R3");
      rd(ca(0,7), "R3");
      chk("R3 count", last_rd, 32'd5);
      rd(ca(0,7), "R3");
      chk("R3 next", last_rd, 32'd6);

      // R12: commands with bit 0 clear do nothing
      wr(ca(0,1), 32'd0, "R12");
      wr(ca(0,2), 32'hFFFF_FFFE, "R12");
      rd(ca(0,7), "R12");
      chk("R12 count", last_rd, 32'd9);

      // R9: stop freezes, clear zeroes without starting
      wr(ca(0,1), 32'd1, "R9");
      idle(3, "R9");
      rd(ca(0,7), "R9");
      rd(ca(0,7), "R9");
      wr(ca(0,2), 32'd1, "R9");
      idle(2, "R9");
      rd(ca(0,7), "R9");
      chk("R9 cleared", last_rd, 32'd0);
      wr(ca(0,0), 32'd1, "R9");

      // R10: staging limit while running
      wr(ca(0,4), 32'd5, "R10");
      rd(ca(0,4), "R10");
      chk("R10 readback", last_rd, 32'd5);
      wr(ca(0,5), 32'd1, "R10");
      idle(12, "R10");
      wr(ca(0,2), 32'd1, "R10");

      // R4/R6: repeating period of 6, interrupt follows
      idle(8, "R4");
      wr(ca(0,6), 32'd1, "R7");
      idle(9, "R4");

      // R8: acknowledge landing on a match
      wr(ca(0,6), 32'd1, "R8");
      for (int i = 0; i < 20; i++) begin
         rd(ca(0,7), "R8");
         if (last_rd == 32'd4) break;
      end
      wr(ca(0,6), 32'd1, "R8");
      rd(ca(0,7), "R8");
      chk("R8 irq kept", {31'd0, irq[0]}, 32'd1);

      // R5: single-event on channel 1
      wr(ca(1,3), 32'd1, "R5");
      wr(ca(1,4), 32'd3, "R5");
      wr(ca(1,5), 32'd1, "R5");
      wr(ca(1,2), 32'd1, "R5");
      wr(ca(1,0), 32'd1, "R5");
      idle(8, "R5");
      rd(ca(1,7), "R5");
      chk("R5 held", last_rd, 32'd3);
      rd(ca(1,7), "R5");

      // R6: gating by enable
      wr(ca(1,5), 32'd0, "R6");
      rd(ca(1,5), "R6");
      chk("R6 off", {31'd0, irq[1]}, 32'd0);
      wr(ca(1,5), 32'd1, "R6");
      rd(ca(1,5), "R6");
      chk("R6 on", {31'd0, irq[1]}, 32'd1);

      // R4: free-running with all-ones limit
      wr(ca(1,3), 32'd0, "R4");
      wr(ca(1,4), 32'hFFFF_FFFF, "R4");
      wr(ca(1,6), 32'd1, "R4");
      wr(ca(1,2), 32'd1, "R4");
      wr(ca(1,0), 32'd1, "R4");
      idle(20, "R4");
      rd(ca(1,7), "R4");
      chk("R4 free", last_rd, 32'd20);

      // R11: unmapped and command words read zero
      rd(AW'(1), "R11"); rd(AW'(15), "R11"); rd(ca(0,0), "R11");
      rd(ca(0,6), "R11"); rd(ca(1,8), "R11"); rd(AW'(8'hF0), "R11");

      // R13: random traffic over both channels
      for (int i = 0; i < 4000; i++) begin
         int c  = int'($urandom % NCH);
         int op = int'($urandom % 100);
         logic [31:0] d = ($urandom % 8 == 0) ? 32'd0 : 32'd1;
         if (op < 40)      rd(ca(c, int'($urandom % 16)), "R13");
         else if (op < 50) wr(ca(c,0), d, "R13");
         else if (op < 55) wr(ca(c,1), d, "R13");
         else if (op < 62) wr(ca(c,2), d, "R13");
         else if (op < 68) wr(ca(c,3), d, "R13");
         else if (op < 78) wr(ca(c,4), ($urandom % 20 == 0) ? 32'hFFFF_FFFF : $urandom % 12, "R13");
         else if (op < 84) wr(ca(c,5), d, "R13");
         else if (op < 95) wr(ca(c,6), d, "R13");
         else if (op < 97) wr(AW'(0), ($urandom % 4 == 0) ? 32'd0 : 32'd1, "R13");
         else              idle(1, "R13");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule